// File: doc/BRIEF.md
# Carry-Free Redundant Decimal Adder

This block adds two decimal numbers of `NUM_DIG` digits. Each digit is held in an overloaded form: four weighted bits with any value from 0 to 15, so a digit may go past 9. The result uses the same digit set. Neither operand needs to be normalized first.

For each digit position, the two operand digits are split into an upper bit-set (weights 8 and 4) and a lower bit-set (weights 2 and 1). The values of both sets are formed at the same time. From them the position produces a transfer of 0, 1 or 2 toward the next position and an interim digit. Each final digit is its own interim digit plus the transfer from the position just below it. A carry therefore moves at most one position, and the logic depth does not grow with `NUM_DIG`.

The transfer out of the top position is returned as one extra result digit. The lower digits of the result use the same digit set as the operands, so they can feed straight into another instance of the adder. This makes the block suitable as a 2:1 stage in a partial-product reduction tree. An optional output register sits behind the combinational core.

Top module: `rda_adder`

## Requirements
- R1: Every operand digit is a 4-bit weighted binary value, and all values 0 to 15 are accepted on both operands. Digit i occupies bits [4i+3:4i], and digit 0 is the least significant.
- R2: For the pair total p = a_i + b_i (0 to 30), the outgoing transfer is 0 when p <= 13, 1 when 14 <= p <= 23, and 2 when p >= 24.
- R3: Result digit i equals (p_i - 10*t_i) + t_(i-1), which lies in 0 to 15. Digit 0 receives no incoming transfer.
- R4: The decimal value of the result, sum of d_i*10^i taken over all NUM_DIG+1 digits, equals the decimal value of A plus the decimal value of B.
- R5: The transfer out of the top position (0 to 2) appears as result digit NUM_DIG, at bits [4*NUM_DIG+3:4*NUM_DIG].
- R6: Changing only the operand pair at position k changes no result digit other than digits k and k+1.
- R7: With REG_OUT=1, the result appears on the clock edge after the operands are applied.
- R8: A synchronous active-high reset clears the registered result to zero on the next clock edge.
- R9: The lower NUM_DIG result digits, fed back as an operand of the same adder, give a result that again satisfies R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 4*NUM_DIG | First redundant decimal operand |
| op_b | input | 4*NUM_DIG | Second redundant decimal operand |
| sum_o | output | 4*(NUM_DIG+1) | Redundant sum; the top digit is the final transfer |

## Verification
The bench builds the adder with NUM_DIG=8 and REG_OUT=1. With these values the full result fits in a 64-bit integer, so every result can be checked by its exact decimal value as well as digit by digit. Uniform operands force every position into one transfer band at a time, including each band edge (pair totals 13/14 and 23/24) and the maximum of 30. Eight positions are enough to show that a change at one position reaches only the position above it, and one result is fed back through the adder to check the 2:1 reducer use.

// File: rtl/rda_pkg.sv
package rda_pkg;
  localparam int DIG_W  = 4;
  localparam int XFER_W = 2;
  localparam int HALF_W = 2;

  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [XFER_W-1:0] xfer_t;

  // transfer band edges on the pair total
  localparam int BAND1_MIN = 14;
  localparam int BAND2_MIN = 24;
  localparam int RADIX     = 10;
endpackage

// File: rtl/rda_pair_eval.sv
module rda_pair_eval
  import rda_pkg::*;
(
  input  digit_t a_dig,
  input  digit_t b_dig,
  output xfer_t  xfer_o,
  output digit_t interim_o
);
  localparam int SET_W = HALF_W + 1;

  logic [SET_W-1:0] hi_set;   // upper bit-set value, weight 4
  logic [SET_W-1:0] lo_set;   // lower bit-set value, weight 1
  logic             xf_two;
  logic             xf_one;
  logic [5:0]       pair_tot;

  // both bit-set values are formed independently
  always_comb begin
    hi_set = SET_W'(a_dig[DIG_W-1 -: HALF_W]) + SET_W'(b_dig[DIG_W-1 -: HALF_W]);
    lo_set = SET_W'(a_dig[HALF_W-1:0])        + SET_W'(b_dig[HALF_W-1:0]);
  end

  // transfer taken from the two set values in parallel
  always_comb begin
    xf_two = (hi_set == 3'd6) || (hi_set == 3'd5 && lo_set >= 3'd4);
    xf_one = !xf_two &&
             ((hi_set >= 3'd4) ||
              (hi_set == 3'd3 && lo_set >= 3'd2) ||
              (hi_set == 3'd2 && lo_set == 3'd6));
  end

  always_comb begin
    pair_tot  = {1'b0, hi_set, 2'b00} + 6'(lo_set);
    xfer_o    = xf_two ? 2'd2 : (xf_one ? 2'd1 : 2'd0);
    interim_o = DIG_W'(pair_tot - (xf_two ? 6'(2*RADIX) : (xf_one ? 6'(RADIX) : 6'd0)));
  end
endmodule

// File: rtl/rda_out_stage.sv
module rda_out_stage #(
  parameter int WIDTH   = 36,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
      end
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/rda_adder.sv
module rda_adder
  import rda_pkg::*;
#(
  parameter int NUM_DIG = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DIG_W*NUM_DIG-1:0]     op_a,
  input  logic [DIG_W*NUM_DIG-1:0]     op_b,
  output logic [DIG_W*(NUM_DIG+1)-1:0] sum_o
);
  localparam int RES_W = DIG_W * (NUM_DIG + 1);

  xfer_t  xfer   [NUM_DIG];
  digit_t interim[NUM_DIG];
  logic [RES_W-1:0] sum_comb;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DIG; gi++) begin : g_pos
      rda_pair_eval u_eval (
        .a_dig    (op_a[DIG_W*gi +: DIG_W]),
        .b_dig    (op_b[DIG_W*gi +: DIG_W]),
        .xfer_o   (xfer[gi]),
        .interim_o(interim[gi])
      );
      if (gi == 0) begin : g_lsd
        assign sum_comb[0 +: DIG_W] = interim[0];
      end else begin : g_upper
        assign sum_comb[DIG_W*gi +: DIG_W] = interim[gi] + DIG_W'(xfer[gi-1]);
      end
    end
  endgenerate

  assign sum_comb[DIG_W*NUM_DIG +: DIG_W] = DIG_W'(xfer[NUM_DIG-1]);

  rda_out_stage #(.WIDTH(RES_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk),
    .rst(rst),
    .d_i(sum_comb),
    .q_o(sum_o)
  );
endmodule

// File: rtl/rda_adder_chk.sv
module rda_adder_chk #(
  parameter int NUM_DIG = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst,
  input logic [4*NUM_DIG-1:0]     op_a,
  input logic [4*NUM_DIG-1:0]     op_b,
  input logic [4*(NUM_DIG+1)-1:0] sum_o
);
  localparam int RES_W = 4 * (NUM_DIG + 1);

  function automatic longint unsigned dec_val(input logic [RES_W-1:0] v);
    longint unsigned acc = 0;
    for (int i = NUM_DIG; i >= 0; i--) acc = acc * 10 + longint'(v[4*i +: 4]);
    return acc;
  endfunction

  longint unsigned in_val, out_val;
  logic [4:0] low_pair;
  logic       live;

  always_comb begin
    in_val   = dec_val(RES_W'(op_a)) + dec_val(RES_W'(op_b));
    out_val  = dec_val(sum_o);
    low_pair = 5'(op_a[3:0]) + 5'(op_b[3:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_seq
      // R4
      value_match_chk: assert property (@(posedge clk) disable iff (rst)
        live |-> out_val == $past(in_val));
      // R3
      low_digit_mod_chk: assert property (@(posedge clk) disable iff (rst)
        live |-> (sum_o[3:0] % 10) == ($past(low_pair) % 10));
      // R8
      reset_clear_chk: assert property (@(posedge clk)
        rst |=> sum_o == '0);
    end else begin : g_comb
      // R4
      value_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_val == in_val);
      // R3
      low_digit_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_o[3:0] % 10) == (low_pair % 10));
    end
  endgenerate

  // R5
  top_xfer_range_chk: assert property (@(posedge clk) disable iff (rst)
    sum_o[4*NUM_DIG +: 4] <= 4'd2);
endmodule

bind rda_adder rda_adder_chk #(.NUM_DIG(NUM_DIG), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sum_o(sum_o)
);

// File: tb/rda_adder_tb_top.sv
module rda_adder_tb_top;
  localparam int ND    = 8;
  localparam int VEC_W = 4 * ND;
  localparam int RES_W = 4 * (ND + 1);
  localparam int NVEC  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VEC_W-1:0] op_a = '0, op_b = '0;
  logic [RES_W-1:0] sum_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rda_adder #(.NUM_DIG(ND), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sum_o(sum_o)
  );

  // operand A, operand B, expected result (worked out by hand from R2/R3)
  localparam logic [VEC_W+VEC_W+RES_W-1:0] VEC_TAB [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 36'h0_0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 36'h2_CCCC_CCCA},
    {32'h9999_9999, 32'h0000_0001, 36'h0_9999_999A},
    {32'h6666_6666, 32'h7777_7777, 36'h0_DDDD_DDDD},
    {32'h7777_7777, 32'h7777_7777, 36'h1_5555_5554},
    {32'hFFFF_FFFF, 32'h8888_8888, 36'h1_EEEE_EEED},
    {32'hCCCC_CCCC, 32'hCCCC_CCCC, 36'h2_6666_6664},
    {32'h2222_2222, 32'h4444_4444, 36'h0_6666_6666}
  };

  function automatic logic [RES_W-1:0] ref_add(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    logic [RES_W-1:0] r = '0;
    int t_in = 0;
    for (int i = 0; i < ND; i++) begin
      int p = int'(a[4*i +: 4]) + int'(b[4*i +: 4]);
      int t = (p >= 24) ? 2 : ((p >= 14) ? 1 : 0);
      r[4*i +: 4] = 4'(p - 10 * t + t_in);
      t_in = t;
    end
    r[4*ND +: 4] = 4'(t_in);
    return r;
  endfunction

  function automatic longint unsigned dval(input logic [RES_W-1:0] v);
    longint unsigned acc = 0;
    for (int i = ND; i >= 0; i--) acc = acc * 10 + longint'(v[4*i +: 4]);
    return acc;
  endfunction

  task automatic check(input string req, input logic [RES_W-1:0] got, input logic [RES_W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge (one register)
  task automatic apply(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
    @(negedge clk);
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [RES_W-1:0] base, first;
    repeat (3) @(negedge clk);
    check("R8 reset state", sum_o, '0);
    rst = 1'b0;

    // table walk: R1, R2, R3, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC_TAB[v][2*VEC_W+RES_W-1 -: VEC_W], VEC_TAB[v][VEC_W+RES_W-1 -: VEC_W]);
      check("R2/R3/R5/R7 table", sum_o, VEC_TAB[v][RES_W-1:0]);
      n_cmp++;
      if (dval(sum_o) != dval(RES_W'(op_a)) + dval(RES_W'(op_b))) begin
        n_bad++;
        $display("FAIL R4: got %0d expected %0d", dval(sum_o), dval(RES_W'(op_a)) + dval(RES_W'(op_b)));
      end
    end

    // R1/R4 pattern sweep against the bench model
    for (int k = 0; k < 40; k++) begin
      logic [VEC_W-1:0] a = VEC_W'(32'h9E37_79B9 * (k + 1));
      logic [VEC_W-1:0] b = VEC_W'(32'h85EB_CA6B * (k + 3));
      apply(a, b);
      check("R1/R4 sweep", sum_o, ref_add(a, b));
    end

    // R7: result lags operands by exactly one edge
    @(negedge clk);
    op_a = 32'h1111_1111;
    op_b = 32'h1111_1111;
    @(posedge clk);
    #1;
    op_a = 32'h5555_5555;
    op_b = '0;
    @(negedge clk);
    check("R7 one-edge latency", sum_o, 36'h0_2222_2222);

    // R6 locality: change only position 3
    apply(32'h5555_5555, 32'h5555_5555);
    base = sum_o;
    check("R6 base", base, 36'h0_AAAA_AAAA);
    apply(32'h5555_F555, 32'h5555_5555);
    check("R6 only digits 3,4 move", sum_o, 36'h0_AAAB_AAAA);

    // R9 feed back lower digits as an operand
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    first = sum_o;
    apply(first[VEC_W-1:0], first[VEC_W-1:0]);
    check("R9 reduce-again", sum_o, 36'h2_6666_665A);

    // R8 mid-run reset with live operands
    @(negedge clk);
    op_a = 32'h9999_9999;
    op_b = 32'h9999_9999;
    rst = 1'b1;
    @(negedge clk);
    check("R8 synchronous clear", sum_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 resume", sum_o, ref_add(32'h9999_9999, 32'h9999_9999));

    finish_run();
  end
endmodule